// File: doc/BRIEF.md
# Six-Channel Sequential Sample Loader

This block takes 10-bit sample words from one shared bus and steers them into six channel holding registers. Each word goes into its own register on successive active edges of a slow external load clock. A separate transfer strobe then copies all six holding registers at once into output registers. Downstream logic can therefore see a complete, coherent set of words while the next set is being loaded.

The external load clock is not used as a clock. A fast system clock samples it as data, and a synchronizer with an edge detector turns it into rising and falling events, so every register sits in one clock domain. Two static straps configure the block. One picks which load-clock polarity captures data. The other picks whether a sequence fills channel 0 upward or channel 5 downward. A start strobe arms a sequence one active edge ahead. The transfer is sampled on a rising edge and committed on the falling edge that follows. A polarity flag is latched together with the transfer and presented next to the output words.

Top module: `seq_word_loader`

## Requirements
- R1: A synchronous reset (`rst` high at a `clk` edge) clears every holding and output register, the polarity output, the busy flag, the channel pointer and the armed-start state. After reset `ch_flat` reads zero and `busy` is low.
- R2: When `edge_sel` is 1, words are captured on rising edges of `ext_clk`. When it is 0, they are captured on falling edges. Edges of the other polarity never capture. The effect of an edge shows at the outputs no later than five `clk` cycles after it.
- R3: Channel k occupies `ch_flat[k*10 +: 10]`, with bit 9 of each word the most significant. With `dir_sel` = 0 a sequence writes channels 0,1,2,3,4,5 in that order. With `dir_sel` = 1 it writes 5,4,3,2,1,0.
- R4: A sequence begins on an active edge only if `start_req` was 1 at the previous active edge. The word on `din` at that edge goes to the first channel of the selected direction. An armed start that arrives during a sequence restarts it at the first channel.
- R5: `busy` rises with the first word of a sequence and falls with the sixth. After the sixth word, active edges leave every holding register unchanged until a new start is armed.
- R6: If `xfer_req` is 1 at a rising edge of `ext_clk`, all six holding registers are copied to the outputs on the next falling edge. At no other time do the outputs change.
- R7: A transfer taken during an incomplete sequence outputs the holding contents as they stand at that falling edge. Channels not yet reloaded keep their older words. In falling-edge mode, a word captured on that same falling edge is not included.
- R8: `pol_in` is sampled at the rising edge that accepts the transfer. It appears on `pol_out` at the same time as the copied words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the load clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_clk | input | 1 | External load clock, treated as data |
| din | input | 10 | Sample word, bit 9 most significant |
| edge_sel | input | 1 | 1 = capture on rising load-clock edges, 0 = falling |
| dir_sel | input | 1 | 0 = fill channel 0 upward, 1 = fill channel 5 downward |
| start_req | input | 1 | Start strobe, arms a sequence for the next active edge |
| xfer_req | input | 1 | Transfer strobe, sampled on rising load-clock edges |
| pol_in | input | 1 | Polarity flag latched with a transfer |
| ch_flat | output | 60 | Six output words, channel k at bits k*10+9 down to k*10 |
| pol_out | output | 1 | Polarity bit committed with the last transfer |
| busy | output | 1 | High while a load sequence is incomplete |

## Verification
The holding registers are not visible until a transfer commits them. So a wrong pointer, a wrong fill direction or a missed arm shows up only at the next falling load-clock edge that carries a transfer. At that point one or more channel words come out misplaced, stale or missing. An error in the busy or word-count state is visible sooner, within five system cycles of the active edge, through `busy`. It also shows at the next transfer, when words meant to be ignored appear at the outputs. Mistakes in edge polarity or transfer ordering appear as a word that is either present or absent in the committed set on the mixed-mode transfer edge.

// File: rtl/seqld_pkg.sv
package seqld_pkg;

  // Channel a sequence starts from: lowest for upward fill, highest for downward
  function automatic int first_chan(input logic down, input int nch);
    return down ? (nch - 1) : 0;
  endfunction

  // Channel that follows idx in the selected fill direction
  function automatic int step_chan(input int idx, input logic down);
    return down ? (idx - 1) : (idx + 1);
  endfunction

endpackage

// File: rtl/seqld_edge_det.sv
module seqld_edge_det #(
  parameter int BW     = 15,
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ext_clk,
  input  logic [BW-1:0] ext_bus,
  output logic [BW-1:0] bus_s,
  output logic          rise_ev,
  output logic          fall_ev
);

  logic [STAGES:0] clk_sh;
  logic [BW-1:0]   bus_sh [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_sh <= '0;
      for (int i = 0; i < STAGES; i++) bus_sh[i] <= '0;
    end else begin
      clk_sh <= {clk_sh[STAGES-1:0], ext_clk};
      bus_sh[0] <= ext_bus;
      for (int i = 1; i < STAGES; i++) bus_sh[i] <= bus_sh[i-1];
    end
  end

  assign bus_s   = bus_sh[STAGES-1];
  assign rise_ev =  clk_sh[STAGES-1] & ~clk_sh[STAGES];
  assign fall_ev = ~clk_sh[STAGES-1] &  clk_sh[STAGES];

endmodule

// File: rtl/seqld_fill_ctrl.sv
module seqld_fill_ctrl
  import seqld_pkg::*;
#(
  parameter int NCH = 6,
  parameter int IW  = $clog2(NCH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          act_ev,
  input  logic          start_s,
  input  logic          dir_s,
  output logic          wr_en,
  output logic [IW-1:0] wr_idx,
  output logic          busy,
  output logic          armed
);

  localparam int CW = $clog2(NCH + 1);

  logic [IW-1:0] ptr_q;
  logic [CW-1:0] left_q;
  logic          busy_q;
  logic          armed_q;
  logic [IW-1:0] first_idx;

  assign first_idx = IW'(first_chan(dir_s, NCH));
  assign wr_en     = act_ev && (armed_q || busy_q);
  assign wr_idx    = armed_q ? first_idx : ptr_q;
  assign busy      = busy_q;
  assign armed     = armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q   <= '0;
      left_q  <= '0;
      busy_q  <= 1'b0;
      armed_q <= 1'b0;
    end else if (act_ev) begin
      armed_q <= start_s;
      if (armed_q) begin
        ptr_q  <= IW'(step_chan(int'(first_idx), dir_s));
        left_q <= CW'(NCH - 1);
        busy_q <= (NCH > 1);
      end else if (busy_q) begin
        ptr_q  <= IW'(step_chan(int'(ptr_q), dir_s));
        left_q <= left_q - CW'(1);
        busy_q <= (left_q != CW'(1));
      end
    end
  end

endmodule

// File: rtl/seqld_hold_bank.sv
module seqld_hold_bank #(
  parameter int NCH = 6,
  parameter int DW  = 10,
  parameter int IW  = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IW-1:0]     wr_idx,
  input  logic [DW-1:0]     wr_data,
  output logic [NCH*DW-1:0] hold_flat
);

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    logic [DW-1:0] word_q;
    always_ff @(posedge clk) begin
      if (rst)                                 word_q <= '0;
      else if (wr_en && (wr_idx == IW'(g)))    word_q <= wr_data;
    end
    assign hold_flat[g*DW +: DW] = word_q;
  end

endmodule

// File: rtl/seqld_out_stage.sv
module seqld_out_stage #(
  parameter int NCH = 6,
  parameter int DW  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rise_ev,
  input  logic              fall_ev,
  input  logic              xfer_s,
  input  logic              pol_s,
  input  logic [NCH*DW-1:0] hold_flat,
  output logic [NCH*DW-1:0] ch_flat,
  output logic              pol_out,
  output logic              xfer_fire
);

  logic pend_q;
  logic pol_lat_q;

  assign xfer_fire = fall_ev && pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q    <= 1'b0;
      pol_lat_q <= 1'b0;
      ch_flat   <= '0;
      pol_out   <= 1'b0;
    end else begin
      if (rise_ev && xfer_s) begin
        pend_q    <= 1'b1;
        pol_lat_q <= pol_s;
      end else if (xfer_fire) begin
        pend_q <= 1'b0;
      end
      if (xfer_fire) begin
        ch_flat <= hold_flat;
        pol_out <= pol_lat_q;
      end
    end
  end

endmodule

// File: rtl/seq_word_loader.sv
module seq_word_loader #(
  parameter int NCH    = 6,
  parameter int DW     = 10,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ext_clk,
  input  logic [DW-1:0]     din,
  input  logic              edge_sel,
  input  logic              dir_sel,
  input  logic              start_req,
  input  logic              xfer_req,
  input  logic              pol_in,
  output logic [NCH*DW-1:0] ch_flat,
  output logic              pol_out,
  output logic              busy
);

  localparam int IW = $clog2(NCH);
  localparam int BW = DW + 5;

  logic [BW-1:0]     bus_s;
  logic              rise_ev, fall_ev, act_ev;
  logic [DW-1:0]     din_s;
  logic              edge_s, dir_s, start_s, xfer_s, pol_s;
  logic              wr_en, armed, xfer_fire;
  logic [IW-1:0]     wr_idx;
  logic [NCH*DW-1:0] hold_flat;

  seqld_edge_det #(.BW(BW), .STAGES(STAGES)) u_edge (
    .clk(clk), .rst(rst), .ext_clk(ext_clk),
    .ext_bus({pol_in, xfer_req, start_req, dir_sel, edge_sel, din}),
    .bus_s(bus_s), .rise_ev(rise_ev), .fall_ev(fall_ev)
  );

  assign {pol_s, xfer_s, start_s, dir_s, edge_s, din_s} = bus_s;
  assign act_ev = edge_s ? rise_ev : fall_ev;

  seqld_fill_ctrl #(.NCH(NCH), .IW(IW)) u_ctrl (
    .clk(clk), .rst(rst), .act_ev(act_ev), .start_s(start_s), .dir_s(dir_s),
    .wr_en(wr_en), .wr_idx(wr_idx), .busy(busy), .armed(armed)
  );

  seqld_hold_bank #(.NCH(NCH), .DW(DW), .IW(IW)) u_hold (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(din_s),
    .hold_flat(hold_flat)
  );

  seqld_out_stage #(.NCH(NCH), .DW(DW)) u_out (
    .clk(clk), .rst(rst), .rise_ev(rise_ev), .fall_ev(fall_ev),
    .xfer_s(xfer_s), .pol_s(pol_s), .hold_flat(hold_flat),
    .ch_flat(ch_flat), .pol_out(pol_out), .xfer_fire(xfer_fire)
  );

endmodule

// File: rtl/seqld_chk.sv
module seqld_chk #(
  parameter int NCH = 6,
  parameter int DW  = 10,
  parameter int IW  = $clog2(NCH)
) (
  input logic              clk,
  input logic              rst,
  input logic              act_ev,
  input logic              wr_en,
  input logic [IW-1:0]     wr_idx,
  input logic              busy,
  input logic              armed,
  input logic              xfer_fire,
  input logic              pol_out,
  input logic [NCH*DW-1:0] hold_flat,
  input logic [NCH*DW-1:0] ch_flat
);

  a_r3_idx_range: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (int'(wr_idx) < NCH));

  a_r4_arm_starts: assert property (@(posedge clk) disable iff (rst)
    (act_ev && armed) |=> busy);

  a_r5_busy_fall_on_write: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(wr_en));

  a_r5_idle_no_write: assert property (@(posedge clk) disable iff (rst)
    (!busy && !armed) |=> $stable(hold_flat));

  a_r6_out_hold: assert property (@(posedge clk) disable iff (rst)
    !xfer_fire |=> ($stable(ch_flat) && $stable(pol_out)));

endmodule

bind seq_word_loader seqld_chk #(.NCH(NCH), .DW(DW), .IW(IW)) u_chk (
  .clk(clk), .rst(rst), .act_ev(act_ev), .wr_en(wr_en), .wr_idx(wr_idx),
  .busy(busy), .armed(armed), .xfer_fire(xfer_fire), .pol_out(pol_out),
  .hold_flat(hold_flat), .ch_flat(ch_flat)
);

// File: tb/sim_seq_word_loader.sv
`timescale 1ns/1ps
module sim_seq_word_loader;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ext_clk = 1'b0;
  logic [9:0]  din = '0;
  logic        edge_sel = 1'b1, dir_sel = 1'b0;
  logic        start_req = 1'b0, xfer_req = 1'b0, pol_in = 1'b0;
  logic [59:0] ch_flat;
  logic        pol_out, busy;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // bench model built from the requirements
  logic [9:0] mh [6];
  logic [9:0] mo [6];
  bit m_arm, m_busy, m_pend, m_pol, m_pol_l;
  int m_ptr, m_left;

  always #2.5 clk = ~clk;

  seq_word_loader u0 (
    .clk(clk), .rst(rst), .ext_clk(ext_clk), .din(din), .edge_sel(edge_sel),
    .dir_sel(dir_sel), .start_req(start_req), .xfer_req(xfer_req),
    .pol_in(pol_in), .ch_flat(ch_flat), .pol_out(pol_out), .busy(busy)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int word_of(input int k);
    return int'(ch_flat[k*10 +: 10]);
  endfunction

  task automatic m_load(input logic [9:0] d, input bit st);
    if (m_arm) begin
      int idx = dir_sel ? 5 : 0;
      mh[idx] = d;
      m_ptr = dir_sel ? idx - 1 : idx + 1;
      m_left = 5;
      m_busy = 1;
    end else if (m_busy) begin
      mh[m_ptr] = d;
      m_ptr = dir_sel ? m_ptr - 1 : m_ptr + 1;
      m_left--;
      m_busy = (m_left != 0);
    end
    m_arm = st;
  endtask

  // one full load-clock period, inputs held across both edges
  task automatic step(input logic [9:0] d, input bit st, input bit xf, input bit pl);
    din = d; start_req = st; xfer_req = xf; pol_in = pl;
    wait_clk(4);
    ext_clk = 1'b1;
    if (edge_sel) m_load(d, st);
    if (xf) begin m_pend = 1; m_pol_l = pl; end
    wait_clk(5);
    ext_clk = 1'b0;
    if (m_pend) begin
      for (int k = 0; k < 6; k++) mo[k] = mh[k];
      m_pol = m_pol_l; m_pend = 0;
    end
    if (!edge_sel) m_load(d, st);
    wait_clk(5);
  endtask

  task automatic chk_model(input string tag);
    for (int k = 0; k < 6; k++) chk({tag, " ch"}, word_of(k), int'(mo[k]));
    chk({tag, " pol"}, int'(pol_out), int'(m_pol));
    chk({tag, " busy"}, int'(busy), int'(m_busy));
  endtask

  task automatic t_reset();
    wait_clk(3);
    rst = 1'b0;
    wait_clk(2);
    for (int k = 0; k < 6; k++) begin mh[k] = '0; mo[k] = '0; end
    m_arm = 0; m_busy = 0; m_pend = 0; m_pol = 0; m_pol_l = 0;
    chk("R1 ch_flat zero", (ch_flat == '0) ? 1 : 0, 1);
    chk("R1 busy low", int'(busy), 0);
    chk("R1 pol low", int'(pol_out), 0);
  endtask

  // full sequence in one edge/direction mode, ignored edges, then transfer
  task automatic t_fill(input bit e, input bit dr, input logic [9:0] base, input bit pl);
    edge_sel = e; dir_sel = dr;
    step(10'h000, 1, 0, 0);
    chk("R4 no capture on arming edge", int'(busy), 0);
    for (int k = 0; k < 6; k++) begin
      step(base + 10'(k), 0, 0, 0);
      if (k == 0) chk("R5 busy after first word", int'(busy), 1);
    end
    chk("R5 busy clear after sixth", int'(busy), 0);
    step(10'h3FF, 0, 0, 0);
    step(10'h3FE, 0, 0, 0);
    step(10'h155, 0, 1, pl);
    chk_model("R2 R5 R6 full");
    for (int k = 0; k < 6; k++)
      chk("R3 channel order", word_of(dr ? 5 - k : k), int'(base + 10'(k)));
    chk("R8 polarity", int'(pol_out), int'(pl));
  endtask

  // rising mode: transfer mid-sequence, then restart while busy
  task automatic t_partial_rise();
    edge_sel = 1; dir_sel = 0;
    step(10'h000, 1, 0, 0);
    step(10'h101, 0, 0, 0);
    step(10'h102, 0, 0, 0);
    step(10'h103, 0, 1, 1);
    chk_model("R7 partial rising");
    chk("R7 third word included", word_of(2), 'h103);
    chk("R7 busy still high", int'(busy), 1);
    step(10'h104, 1, 0, 0);
    step(10'h1A0, 0, 0, 0);
    step(10'h1A1, 0, 1, 0);
    chk_model("R4 restart");
    chk("R4 restart at ch0", word_of(0), 'h1A0);
    chk("R4 restart ch1", word_of(1), 'h1A1);
    chk("R4 pre-restart word", word_of(3), 'h104);
  endtask

  // falling mode: a word captured on the transfer's falling edge is excluded
  task automatic t_partial_fall();
    logic [9:0] old3;
    for (int k = 0; k < 6; k++) begin step(10'h0, 0, 0, 0); end
    edge_sel = 0; dir_sel = 1;
    old3 = mh[3];
    step(10'h000, 1, 0, 0);
    step(10'h2A5, 0, 0, 0);
    step(10'h2A4, 0, 0, 0);
    step(10'h2A3, 0, 1, 1);
    chk_model("R7 partial falling");
    chk("R7 same-edge word excluded", word_of(3), int'(old3));
    chk("R7 ch5 loaded", word_of(5), 'h2A5);
    step(10'h2A2, 0, 1, 0);
    chk_model("R7 next transfer");
    chk("R7 word now visible", word_of(3), 'h2A3);
    chk("R8 polarity cleared", int'(pol_out), 0);
  endtask

  initial begin
    t_reset();
    t_fill(1, 0, 10'h010, 1);
    t_fill(1, 1, 10'h220, 0);
    t_fill(0, 0, 10'h330, 1);
    t_fill(0, 1, 10'h140, 1);
    t_partial_rise();
    t_partial_fall();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule